// File: doc/BRIEF.md
# Asynchronous SRAM Write Cycle Sequencer

This block drives one write cycle at a time into an external asynchronous SRAM that has byte lanes. A client offers a write on a valid/ready handshake. The write carries an address, a 16-bit data word and two byte-enable bits. It also carries two control bits: one asks for output enable to stay asserted during the write, and the other picks which strobe is timed. The sequencer then steps the memory pins through three phases: address setup, the write strobe and the hold. Each phase lasts a whole number of clock cycles, set by parameters.

Two strobe styles are available. In the first, chip select goes low for the whole cycle and the write-enable line carries the timed pulse. In the second, write enable goes low for the whole cycle and chip select carries the pulse. If output enable stays low during a write-enable-strobed cycle, the memory is still driving its data pins when the pulse begins. The pulse is then stretched so that the memory can release the bus and the new data can still meet its setup time. The semaphore select is always held inactive, so every access reaches the RAM array.

The handshake stays closed for a whole write-cycle time. Requests issued back to back therefore never break the memory's minimum cycle time.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset, all memory strobes (chip select, write enable, output enable, both lane selects, semaphore select) are high, the data-drive enable is low and req_ready is high.
- R2: sram_sem_n is high in every cycle.
- R3: A request is taken only on a cycle with req_valid and req_ready both high. req_ready then stays low for TOTAL cycles and returns high afterwards. TOTAL is the larger of T_WC and the sum of the setup, pulse and hold phases. Requests offered while req_ready is low have no effect on any pin.
- R4: In write-enable strobe mode (req_ce_strobe=0), sram_ce_n is low from the first cycle after acceptance until the hold phase ends. sram_we_n falls exactly T_AS cycles after acceptance.
- R5: In write-enable strobe mode, the write pulse lasts T_PW cycles when req_oe_low=0. When req_oe_low=1 it lasts max(T_PW, T_HZWE+T_SD) cycles.
- R6: In chip-select strobe mode (req_ce_strobe=1), sram_we_n is low over the setup, pulse and hold phases. sram_ce_n is low only for the T_PW cycles of the pulse, which begins T_AS cycles after acceptance.
- R7: sram_ub_n is low over the setup, pulse and hold phases exactly when req_be[1]=1, and sram_lb_n likewise when req_be[0]=1. Both are high at all other times.
- R8: sram_dq_oe is high during the last T_SD cycles of the pulse and the first T_HD cycles of the hold phase, and low at all other times. It is never high while both chip select and write enable are high.
- R9: sram_addr and sram_dq_out show the accepted address and data and do not change while req_ready is low.
- R10: sram_oe_n is low over the setup, pulse and hold phases when req_oe_low=1, and high otherwise.
- R11: The hold phase lasts max(T_HD, T_HA) cycles. Any remaining cycles up to TOTAL are a recovery phase in which every strobe is high and the data bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | AW | Word address |
| req_data | input | DW | Write data |
| req_be | input | 2 | Lane enables, bit 1 upper, bit 0 lower |
| req_oe_low | input | 1 | Keep output enable low during the cycle |
| req_ce_strobe | input | 1 | 1: chip select is the timed strobe; 0: write enable is |
| sram_addr | output | AW | Address pins |
| sram_dq_out | output | DW | Data to the bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_ub_n | output | 1 | Upper lane select, active low |
| sram_lb_n | output | 1 | Lower lane select, active low |
| sram_sem_n | output | 1 | Semaphore select, held high |

## Verification
All pin levels are decoded combinationally from the phase register and its down-counter. A wrong phase or a counter that is off by one therefore shows on the pins in the same cycle. It appears as an edge of the strobe or of the drive enable that comes one cycle early or late. It also appears as a pulse of the wrong length when output enable is low, or as req_ready returning before or after the full cycle time. A wrongly latched request shows as a changed address, data or lane select in the first cycle after acceptance. The bench compares every pin in every cycle of each write against a timeline it works out from the parameters, so any of these faults is reported in the cycle where it appears.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    localparam int NLANE = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_RECOV
    } phase_e;

    typedef struct packed {
        logic [NLANE-1:0] be;
        logic             oe_low;
        logic             ce_strobe;
    } wr_ctl_t;

    typedef struct packed {
        logic             ce_n;
        logic             we_n;
        logic             oe_n;
        logic [NLANE-1:0] lane_n;
        logic             dq_oe;
    } pin_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int v);
        return $clog2(v + 1) + 1;
    endfunction

endpackage

// File: rtl/sram_wr_capture.sv
module sram_wr_capture
    import sram_wr_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  wr_ctl_t       ctl_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output wr_ctl_t       ctl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            ctl_q  <= '0;
        end else if (take) begin
            addr_q <= addr_in;
            data_q <= data_in;
            ctl_q  <= ctl_in;
        end
    end

endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
    import sram_wr_pkg::*;
#(
    parameter int T_AS   = 2,
    parameter int T_PW   = 3,
    parameter int T_HZWE = 3,
    parameter int T_SD   = 2,
    parameter int T_HD   = 1,
    parameter int T_HA   = 2,
    parameter int T_WC   = 8,
    localparam int PW_EXT   = imax(T_PW, T_HZWE + T_SD),
    localparam int HOLD_N   = imax(T_HD, T_HA),
    localparam int USED_MAX = T_AS + PW_EXT + HOLD_N,
    localparam int CW       = cnt_width(imax(T_WC, USED_MAX))
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  wr_ctl_t       ctl_in,
    output phase_e        phase,
    output logic [CW-1:0] left
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] plen_sel, used_sel, rec_sel;
    logic [CW-1:0] plen_q, rec_q;

    always_comb begin
        plen_sel = (ctl_in.oe_low && !ctl_in.ce_strobe) ? CW'(PW_EXT) : CW'(T_PW);
        used_sel = CW'(T_AS) + plen_sel + CW'(HOLD_N);
        rec_sel  = (CW'(T_WC) > used_sel) ? (CW'(T_WC) - used_sel) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            left   <= '0;
            plen_q <= '0;
            rec_q  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_SETUP;
                        left   <= CW'(T_AS - 1);
                        plen_q <= plen_sel;
                        rec_q  <= rec_sel;
                    end
                end
                PH_SETUP: begin
                    if (left == '0) begin
                        phase <= PH_PULSE;
                        left  <= plen_q - ONE;
                    end else begin
                        left <= left - ONE;
                    end
                end
                PH_PULSE: begin
                    if (left == '0) begin
                        phase <= PH_HOLD;
                        left  <= CW'(HOLD_N - 1);
                    end else begin
                        left <= left - ONE;
                    end
                end
                PH_HOLD: begin
                    if (left == '0) begin
                        if (rec_q != '0) begin
                            phase <= PH_RECOV;
                            left  <= rec_q - ONE;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end else begin
                        left <= left - ONE;
                    end
                end
                PH_RECOV: begin
                    if (left == '0) phase <= PH_IDLE;
                    else            left  <= left - ONE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
    import sram_wr_pkg::*;
#(
    parameter int T_SD = 2,
    parameter int T_HD = 1,
    parameter int T_HA = 2,
    parameter int CW   = 5
) (
    input  phase_e        phase,
    input  logic [CW-1:0] left,
    input  wr_ctl_t       ctl,
    output pin_t          pins
);

    localparam int HOLD_N     = imax(T_HD, T_HA);
    localparam int DRIVE_FROM = HOLD_N - T_HD;

    logic             active, strobe, in_hold;
    logic [NLANE-1:0] lane_n;

    assign active  = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
    assign strobe  = (phase == PH_PULSE);
    assign in_hold = (phase == PH_HOLD);

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign lane_n[i] = !(active && ctl.be[i]);
    end

    always_comb begin
        pins.ce_n   = ctl.ce_strobe ? !strobe : !active;
        pins.we_n   = ctl.ce_strobe ? !active : !strobe;
        pins.oe_n   = !(active && ctl.oe_low);
        pins.lane_n = lane_n;
        pins.dq_oe  = (strobe && (left < CW'(T_SD)))
                   || (in_hold && (left >= CW'(DRIVE_FROM)));
    end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int AW     = 12,
    parameter int DW     = 16,
    parameter int T_AS   = 2,
    parameter int T_PW   = 3,
    parameter int T_HZWE = 3,
    parameter int T_SD   = 2,
    parameter int T_HD   = 1,
    parameter int T_HA   = 2,
    parameter int T_WC   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [1:0]    req_be,
    input  logic          req_oe_low,
    input  logic          req_ce_strobe,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic          sram_ub_n,
    output logic          sram_lb_n,
    output logic          sram_sem_n
);

    localparam int PW_EXT   = imax(T_PW, T_HZWE + T_SD);
    localparam int HOLD_N   = imax(T_HD, T_HA);
    localparam int USED_MAX = T_AS + PW_EXT + HOLD_N;
    localparam int CW       = cnt_width(imax(T_WC, USED_MAX));

    wr_ctl_t       ctl_in, ctl_q;
    phase_e        phase;
    logic [CW-1:0] left;
    logic          take;
    pin_t          pins;

    assign ctl_in = '{be: req_be, oe_low: req_oe_low, ce_strobe: req_ce_strobe};
    assign req_ready = (phase == PH_IDLE);
    assign take = req_valid && req_ready;

    sram_wr_capture #(.AW(AW), .DW(DW)) cap_i (
        .clk(clk), .rst(rst), .take(take),
        .addr_in(req_addr), .data_in(req_data), .ctl_in(ctl_in),
        .addr_q(sram_addr), .data_q(sram_dq_out), .ctl_q(ctl_q)
    );

    sram_wr_fsm #(
        .T_AS(T_AS), .T_PW(T_PW), .T_HZWE(T_HZWE), .T_SD(T_SD),
        .T_HD(T_HD), .T_HA(T_HA), .T_WC(T_WC)
    ) fsm_i (
        .clk(clk), .rst(rst), .start(take), .ctl_in(ctl_in),
        .phase(phase), .left(left)
    );

    sram_wr_pins #(.T_SD(T_SD), .T_HD(T_HD), .T_HA(T_HA), .CW(CW)) pins_i (
        .phase(phase), .left(left), .ctl(ctl_q), .pins(pins)
    );

    assign sram_ce_n  = pins.ce_n;
    assign sram_we_n  = pins.we_n;
    assign sram_oe_n  = pins.oe_n;
    assign sram_ub_n  = pins.lane_n[1];
    assign sram_lb_n  = pins.lane_n[0];
    assign sram_dq_oe = pins.dq_oe;
    assign sram_sem_n = 1'b1;

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] sram_addr,
    input logic [DW-1:0] sram_dq_out,
    input logic          sram_dq_oe,
    input logic          sram_ce_n,
    input logic          sram_we_n,
    input logic          sram_ub_n,
    input logic          sram_lb_n
);

    AST_ACCEPT_CLOSES_READY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R3

    AST_NO_TWIN_FALL: assert property (@(posedge clk) disable iff (rst)
        !($fell(sram_ce_n) && $fell(sram_we_n))); // R4

    AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> (!sram_ce_n || !sram_we_n)); // R8

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> ($stable(sram_addr) && $stable(sram_dq_out))); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_ce_n && sram_we_n && sram_ub_n && sram_lb_n && !sram_dq_oe)); // R11

endmodule

bind sram_wr_seq sram_wr_seq_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n)
);

// File: tb/sram_wr_seq_tb_top.sv
module sram_wr_seq_tb_top;

    localparam int AW = 12, DW = 16;
    localparam int TAS = 2, TPW = 3, THZ = 3, TSD = 2, THD = 1, THA = 2, TWC = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_ready, req_oe_low, req_ce_strobe;
    logic [AW-1:0] req_addr, sram_addr;
    logic [DW-1:0] req_data, sram_dq_out;
    logic [1:0]    req_be;
    logic          sram_dq_oe, sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, sram_sem_n;

    int total_n = 0;
    int bad_n   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    sram_wr_seq #(
        .AW(AW), .DW(DW), .T_AS(TAS), .T_PW(TPW), .T_HZWE(THZ), .T_SD(TSD),
        .T_HD(THD), .T_HA(THA), .T_WC(TWC)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
        .req_oe_low(req_oe_low), .req_ce_strobe(req_ce_strobe),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n), .sram_sem_n(sram_sem_n)
    );

    function automatic int bmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total_n++;
        if (act !== exp) begin
            bad_n++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(tag, "ce_n idle", sram_ce_n, 1);
        chk(tag, "we_n idle", sram_we_n, 1);
        chk(tag, "oe_n idle", sram_oe_n, 1);
        chk(tag, "ub_n idle", sram_ub_n, 1);
        chk(tag, "lb_n idle", sram_lb_n, 1);
        chk(tag, "dq_oe idle", sram_dq_oe, 0);
        chk("R2", "sem_n", sram_sem_n, 1);
        chk(tag, "ready idle", req_ready, 1);
    endtask

    // Called at a negedge while the sequencer is expected to be idle.
    task automatic run_req(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be,
                           input bit oel, input bit ces, input bit noise);
        int p, h, used, tot, pend;
        bit act, pul, hld, exp_ce, exp_we, exp_dq;
        string stag, wtag;
        p    = (oel && !ces) ? bmax(TPW, THZ + TSD) : TPW;
        h    = bmax(THD, THA);
        used = TAS + p + h;
        tot  = bmax(TWC, used);
        pend = TAS + p;
        chk("R3", "ready before request", req_ready, 1);
        req_addr = a; req_data = d; req_be = be;
        req_oe_low = oel; req_ce_strobe = ces; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < tot; k++) begin
            act = (k < used);
            pul = (k >= TAS) && (k < pend);
            hld = (k >= pend) && (k < used);
            exp_ce = ces ? !pul : !act;
            exp_we = ces ? !act : !pul;
            exp_dq = (pul && (k >= pend - TSD)) || (hld && (k < pend + THD));
            stag = !act ? "R11" : (ces ? "R6" : "R4");
            wtag = !act ? "R11" : (ces ? "R6" : "R5");
            chk(stag, $sformatf("ce_n k=%0d", k), sram_ce_n, exp_ce);
            chk(wtag, $sformatf("we_n k=%0d", k), sram_we_n, exp_we);
            chk("R10", $sformatf("oe_n k=%0d", k), sram_oe_n, !(act && oel));
            chk("R7", $sformatf("ub_n k=%0d", k), sram_ub_n, !(act && be[1]));
            chk("R7", $sformatf("lb_n k=%0d", k), sram_lb_n, !(act && be[0]));
            chk("R8", $sformatf("dq_oe k=%0d", k), sram_dq_oe, exp_dq);
            chk("R9", $sformatf("addr k=%0d", k), sram_addr, a);
            chk("R9", $sformatf("data k=%0d", k), sram_dq_out, d);
            chk("R2", $sformatf("sem_n k=%0d", k), sram_sem_n, 1);
            chk("R3", $sformatf("ready busy k=%0d", k), req_ready, 0);
            if (noise) begin
                req_valid = 1'($urandom_range(0, 1));
                req_addr  = AW'($urandom);
                req_data  = DW'($urandom);
                req_be    = 2'($urandom);
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk_idle("R3");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total_n++;
            bad_n++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total_n, bad_n);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_data = '0;
        req_be = 2'b00; req_oe_low = 1'b0; req_ce_strobe = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");

        // Directed: each strobe style with output enable high and low, all lane patterns
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 4; b++) begin
                run_req(AW'(12'h100 + m * 16 + b), DW'(16'hA500 + m * 16 + b), 2'(b),
                        m[0], m[1], 1'b0);
            end
        end

        // Directed: requests held up while busy must be ignored (R3)
        run_req(12'hFFF, 16'hFFFF, 2'b11, 1'b1, 1'b0, 1'b1);
        run_req(12'h000, 16'h0000, 2'b11, 1'b0, 1'b1, 1'b1);

        // Constrained random mix, issued back to back
        for (int n = 0; n < 60; n++) begin
            run_req(AW'($urandom), DW'($urandom), 2'($urandom),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)));
        end

        // A long idle gap keeps every pin quiet
        repeat (5) @(negedge clk);
        chk_idle("R11");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total_n, bad_n);
        $finish;
    end

endmodule